// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers up to 32 interrupt request inputs into one request line toward a processor. Each input is fixed at build time as either edge-triggered or level-sensitive. Every input first passes through a two-flop synchronizer. Captured requests accumulate in a sticky status word. An enable word masks them, and the result forms a pending word. A two-bit master control gates the final request line.

Software reaches the controller through a simple synchronous register bus. The bus has a 3-bit word address, a write strobe, 32-bit write data and combinational 32-bit read data. Enable bits can be written as a whole, or changed one bit at a time through separate set and clear locations, so no read-modify-write is needed. Captured requests are cleared by writing a mask of ones to the acknowledge location. A vector location reports the highest-priority pending input, where input 0 has the highest priority.

Word map, with bit i of every word belonging to input i:

| Offset | Contents |
|---|---|
| 0 | status |
| 1 | pending |
| 2 | enable |
| 3 | acknowledge |
| 4 | set-enable |
| 5 | clear-enable |
| 6 | vector |
| 7 | master control |

Top module: `irqc_top`

## Requirements
- R1: After reset, the status, pending, enable and master control words all read zero, `irq_out` is low, and the vector word (offset 6) reads 0xFFFFFFFF.
- R2: A level-sensitive input (a zero in bit i of `EDGE_MASK`) sets status bit i in every cycle it is high. Acknowledging the bit while the input is still high leaves it reading one. After the input falls, the bit stays set until it is acknowledged.
- R3: An edge-triggered input (a one in bit i of `EDGE_MASK`) sets status bit i only on a low-to-high transition. Acknowledging the bit while the input stays high clears it for good, until the next rising transition.
- R4: A write to offset 3 clears every status bit whose write-data bit is one and leaves the others unchanged. Writing 0xFFFFFFFF clears all captured edge requests.
- R5: A write to offset 4 sets the enable bits whose write-data bit is one and leaves the others unchanged.
- R6: A write to offset 5 clears the enable bits whose write-data bit is one and leaves the others unchanged.
- R7: A write to offset 2 loads the enable word directly. Writing zero disables every input at once.
- R8: The pending word (offset 1) reads as status AND enable.
- R9: The vector word (offset 6) reads the index of the lowest-numbered set pending bit, zero-extended to 32 bits, or 0xFFFFFFFF when no bit is pending.
- R10: The master control word (offset 7) holds write-data bits 1:0. `irq_out` is high exactly when some pending bit is set and both master bits are one.
- R11: Offsets 3, 4 and 5 read zero. Writes to offsets 0, 1 and 6 change no state.
- R12: A change on an input becomes visible in the status word three clock edges after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt request inputs |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Request line to the processor |

## Verification
A corrupted status or enable bit appears in the pending and vector words in the same cycle the bad state exists. When the master bits are both one, it also appears on `irq_out` in that cycle. A wrong edge-detect or synchronizer stage appears as status bits that set one edge early or late, or that set again after an acknowledge while an edge input is held high. The bench therefore reads every register after each operation and probes the exact capture cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 3;

    typedef enum logic [BUS_AW-1:0] {
        RSEL_STATUS  = 3'd0,
        RSEL_PENDING = 3'd1,
        RSEL_ENABLE  = 3'd2,
        RSEL_ACK     = 3'd3,
        RSEL_SETEN   = 3'd4,
        RSEL_CLREN   = 3'd5,
        RSEL_VECTOR  = 3'd6,
        RSEL_MASTER  = 3'd7
    } rsel_e;

    typedef struct packed {
        logic              ack;
        logic              set_en;
        logic              clr_en;
        logic              load_en;
        logic              load_master;
        logic [BUS_DW-1:0] data;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(input logic we,
                                             input logic [BUS_AW-1:0] addr,
                                             input logic [BUS_DW-1:0] d);
        wr_cmd_t c;
        c             = '0;
        c.data        = d;
        c.ack         = we && (rsel_e'(addr) == RSEL_ACK);
        c.set_en      = we && (rsel_e'(addr) == RSEL_SETEN);
        c.clr_en      = we && (rsel_e'(addr) == RSEL_CLREN);
        c.load_en     = we && (rsel_e'(addr) == RSEL_ENABLE);
        c.load_master = we && (rsel_e'(addr) == RSEL_MASTER);
        return c;
    endfunction

endpackage

// File: rtl/irqc_input_stage.sv
module irqc_input_stage #(
    parameter int unsigned NUM_IN    = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    output logic [NUM_IN-1:0] req
);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic s1_q, s2_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= irq_in[i];
                s2_q <= s1_q;
            end
        end

        if (EDGE_MASK[i]) begin : g_edge
            logic s3_q;
            always_ff @(posedge clk) begin
                if (rst) s3_q <= 1'b0;
                else     s3_q <= s2_q;
            end
            assign req[i] = s2_q & ~s3_q;
        end else begin : g_level
            assign req[i] = s2_q;
        end
    end

endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] req,
    input  wr_cmd_t           cmd,
    output logic [NUM_IN-1:0] status_q,
    output logic [NUM_IN-1:0] enable_q,
    output logic [1:0]        master_q,
    output logic [NUM_IN-1:0] pending
);

    logic [NUM_IN-1:0] wmask;
    logic [NUM_IN-1:0] ack_mask;
    logic [NUM_IN-1:0] status_d;
    logic [NUM_IN-1:0] enable_d;

    assign wmask    = cmd.data[NUM_IN-1:0];
    assign ack_mask = cmd.ack ? wmask : '0;

    always_comb begin
        // a new request wins over an acknowledge in the same cycle
        status_d = (status_q & ~ack_mask) | req;
        enable_d = enable_q;
        if (cmd.load_en)     enable_d = wmask;
        else if (cmd.set_en) enable_d = enable_q | wmask;
        else if (cmd.clr_en) enable_d = enable_q & ~wmask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            master_q <= 2'b00;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
            if (cmd.load_master) master_q <= cmd.data[1:0];
        end
    end

    assign pending = status_q & enable_q;

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int unsigned NUM_IN = 32,
    localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] pending,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IN    = 32,
    parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000,
    localparam int unsigned IDX_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);

    wr_cmd_t           cmd;
    logic [NUM_IN-1:0] req;
    logic [NUM_IN-1:0] status_q;
    logic [NUM_IN-1:0] enable_q;
    logic [NUM_IN-1:0] pending;
    logic [1:0]        master_q;
    logic              vec_found;
    logic [IDX_W-1:0]  vec_idx;

    assign cmd = decode_write(bus_we, bus_addr, bus_wdata);

    irqc_input_stage #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) u_in (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .req    (req)
    );

    irqc_core #(.NUM_IN(NUM_IN)) u_core (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cmd      (cmd),
        .status_q (status_q),
        .enable_q (enable_q),
        .master_q (master_q),
        .pending  (pending)
    );

    irqc_prio_enc #(.NUM_IN(NUM_IN)) u_enc (
        .pending (pending),
        .found   (vec_found),
        .idx     (vec_idx)
    );

    logic [31:0] status_x, enable_x, pending_x, vector_x;

    always_comb begin
        status_x                = '0;
        enable_x                = '0;
        pending_x               = '0;
        vector_x                = '1;
        status_x[NUM_IN-1:0]    = status_q;
        enable_x[NUM_IN-1:0]    = enable_q;
        pending_x[NUM_IN-1:0]   = pending;
        if (vec_found) begin
            vector_x            = '0;
            vector_x[IDX_W-1:0] = vec_idx;
        end
    end

    always_comb begin
        unique case (rsel_e'(bus_addr))
            RSEL_STATUS:  bus_rdata = status_x;
            RSEL_PENDING: bus_rdata = pending_x;
            RSEL_ENABLE:  bus_rdata = enable_x;
            RSEL_VECTOR:  bus_rdata = vector_x;
            RSEL_MASTER:  bus_rdata = {30'd0, master_q};
            default:      bus_rdata = '0;
        endcase
    end

    assign irq_out = (|pending) && (master_q == 2'b11);

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_IN = 32,
    localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [2:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_IN-1:0] enable_q,
    input logic [NUM_IN-1:0] pending,
    input logic [1:0]        master_q,
    input logic              irq_out,
    input logic              vec_found,
    input logic [IDX_W-1:0]  vec_idx
);

    logic [NUM_IN-1:0] below_mask;
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < NUM_IN; i++) below_mask[i] = (i < int'(vec_idx));
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (enable_q == '0 && master_q == 2'b00)); // R1

    AST_SETEN_SETS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd4) |=>
            ((enable_q & $past(bus_wdata[NUM_IN-1:0])) == $past(bus_wdata[NUM_IN-1:0]))); // R5

    AST_CLREN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd5) |=>
            ((enable_q & $past(bus_wdata[NUM_IN-1:0])) == '0)); // R6

    AST_DIRECT_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd2) |=> (enable_q == $past(bus_wdata[NUM_IN-1:0]))); // R7

    AST_VECTOR_PENDING: assert property (@(posedge clk) disable iff (rst)
        vec_found |-> (pending[vec_idx] && ((pending & below_mask) == '0))); // R9

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (master_q == 2'b11 && pending != '0)); // R10

    AST_OUT_RAISED: assert property (@(posedge clk) disable iff (rst)
        (master_q == 2'b11 && pending != '0) |-> irq_out); // R10

endmodule

bind irqc_top irqc_checker #(.NUM_IN(NUM_IN)) u_irqc_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .enable_q  (enable_q),
    .pending   (pending),
    .master_q  (master_q),
    .irq_out   (irq_out),
    .vec_found (vec_found),
    .vec_idx   (vec_idx)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam int unsigned NUM_IN = 32;
    localparam logic [31:0] EDGE   = 32'hF0F0_0F0F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_status = '0, m_enable = '0, cur_in = '0;
    logic [1:0]  m_master = '0;

    always #5 clk = ~clk;

    irqc_top #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE)) i_irqc_top (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_vector(input logic [31:0] p);
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            3'd2: m_enable = d;
            3'd3: m_status = (m_status & ~d) | (cur_in & ~EDGE);
            3'd4: m_enable = m_enable | d;
            3'd5: m_enable = m_enable & ~d;
            3'd7: m_master = d[1:0];
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_inputs(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        m_status = m_status | (v & ~cur_in & EDGE) | (v & ~EDGE);
        cur_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] d;
        logic [31:0] p;
        p = m_status & m_enable;
        bus_read(3'd0, d); check({"R2/R3 status ", ctx}, d, m_status);
        bus_read(3'd1, d); check({"R8 pending ", ctx}, d, p);
        bus_read(3'd2, d); check({"R7 enable ", ctx}, d, m_enable);
        bus_read(3'd3, d); check({"R11 ack reads zero ", ctx}, d, 32'h0);
        bus_read(3'd4, d); check({"R11 set reads zero ", ctx}, d, 32'h0);
        bus_read(3'd5, d); check({"R11 clr reads zero ", ctx}, d, 32'h0);
        bus_read(3'd6, d); check({"R9 vector ", ctx}, d, exp_vector(p));
        bus_read(3'd7, d); check({"R10 master ", ctx}, d, {30'd0, m_master});
        check({"R10 irq_out ", ctx}, {31'd0, irq_out},
              {31'd0, (p != 0) && (m_master == 2'b11)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1 reset");

        // R7 enable all, R10 master on
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd7, 32'h3);
        check_all("R7 load all");

        // R12: capture latency on level input 4
        @(negedge clk);
        irq_in = 32'h10;
        @(negedge clk); @(negedge clk);
        bus_addr = 3'd0; #1 check("R12 not yet after two edges", bus_rdata, 32'h0);
        @(negedge clk);
        bus_addr = 3'd0; #1 check("R12 visible after three edges", bus_rdata, 32'h10);
        cur_in = 32'h10; m_status = 32'h10;
        repeat (2) @(negedge clk);

        // R2: level inputs held high survive acknowledge
        set_inputs(32'h0000_00F0);
        bus_write(3'd3, 32'h0000_00F0);
        check_all("R2 ack while high");
        set_inputs(32'h0);
        check_all("R2 sticky after fall");
        bus_write(3'd3, 32'h0000_00F0);
        check_all("R2 ack after fall");

        // R3: edge input 0 cleared for good while held high
        set_inputs(32'h1);
        check_all("R3 rising edge");
        bus_write(3'd3, 32'h1);
        repeat (3) @(negedge clk);
        check_all("R3 held high after ack");
        set_inputs(32'h0);
        set_inputs(32'h1);
        check_all("R3 second edge");

        // R9: lowest index wins
        set_inputs(32'h8000_0101);
        check_all("R9 several pending");
        // R6/R5 single bits
        bus_write(3'd5, 32'h1);
        check_all("R6 clear bit0");
        bus_write(3'd4, 32'h1);
        check_all("R5 set bit0");
        // R10 gated by master
        bus_write(3'd7, 32'h1);
        check_all("R10 master partial");
        bus_write(3'd7, 32'h3);
        // R11 writes to read-only offsets ignored
        bus_write(3'd0, 32'h0);
        bus_write(3'd1, 32'h0);
        bus_write(3'd6, 32'h0);
        check_all("R11 read-only writes");
        // R4 ack all-ones clears edge captures
        set_inputs(32'h0);
        bus_write(3'd3, 32'hFFFF_FFFF);
        check_all("R4 ack all");
        bus_read(3'd0, d); check("R4 status empty", d, 32'h0);
        // R7 write zero disables everything
        set_inputs(32'h0000_0030);
        bus_write(3'd2, 32'h0);
        check_all("R7 disable all");

        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: set_inputs($urandom);
                1: bus_write(3'd4, $urandom);
                2: bus_write(3'd5, $urandom);
                3: bus_write(3'd3, ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom);
                4: bus_write(3'd2, $urandom);
                default: bus_write(3'd7, $urandom % 4);
            endcase
            check_all("random R4 R5 R6 R8 R9 R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule